// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block sits between a byte-wide CPU register port and a 10-bit analog-to-digital conversion core. Software uses a single control register to choose the channel, single-ended or differential mode, the clock prescale, and whether the multiplexor output stays routed to its pin. The same register holds a run bit. Setting the run bit enables a divide-by-1 or divide-by-16 clock enable towards the converter and issues one start pulse on the first prescaled tick. The converter answers with a one-cycle done strobe that carries the 10-bit sample.

When a conversion completes, the block clears the run bit, which stops the converter clock. It splits the sample into a high byte and a left-aligned two-bit low register. Software stops a conversion by clearing the run bit. To restart, it writes 0 and then 1, and the two writes may be back to back. The block also drives the enables for the input-multiplexor gating and the temperature-sensor select.

Top module: `adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, and conv_start_o, conv_clk_en_o, mux_gate_en_o and temp_sel_o are low.
- R2: The register map is: address 0 is control, address 1 is the result high byte, address 2 is the result low register, and address 3 reads 0x00 and ignores writes. The control bits are [3:0] channel, [4] differential (1) or single-ended (0), [5] divide-by-16 (1) or divide-by-1 (0), [6] mux-output enable, and [7] run. All control bits read back as written while run is 0.
- R3: A control write that sets run to 1 while run is 0 produces exactly one conv_start_o pulse, on the first prescaler tick. With divide-by-1, the pulse is in the cycle right after the write edge. With divide-by-16, it is 15 cycles later.
- R4: conv_clk_en_o is low while run is 0. While run is 1 it is high every cycle at divide-by-1, and once per 16 cycles at divide-by-16. The divider restarts from zero every time run is cleared.
- R5: A done strobe accepted while a conversion is running writes sample bits [9:2] to the high register and sample bits [1:0] to bits [7:6] of the low register. It also clears run at the same edge.
- R6: A control write with run = 0 aborts the conversion. A done strobe in that same cycle, or any later one, leaves both result registers unchanged.
- R7: Writing 0 and then 1 to run in back-to-back cycles yields a new start pulse. Writing 1 while run is already 1 gives no new start pulse.
- R8: The CPU can write both result registers. Bits [5:0] of the low register always read 0. Both registers keep their value until the next completed conversion or CPU write.
- R9: mux_gate_en_o is high when run is 1, when mux-output is enabled, or when pga_en_i is high. pin_path_en_o is high only when mux-output is enabled or pga_en_i is high.
- R10: temp_sel_o is high only when the channel is 15 and the mode is single-ended.
- R11: A done strobe is ignored while run is 0, or before the start pulse of the current conversion has been issued. In that case run and the result registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pga_en_i | input | 1 | Gain amplifier enabled |
| conv_clk_en_o | output | 1 | Prescaled clock enable to the converter |
| conv_start_o | output | 1 | One-cycle start pulse |
| conv_chan_o | output | 4 | Selected channel |
| conv_diff_o | output | 1 | Differential mode |
| conv_done_i | input | 1 | Conversion done strobe |
| conv_data_i | input | 10 | Sample, valid with conv_done_i |
| mux_gate_en_o | output | 1 | Multiplexor input gate enable |
| pin_path_en_o | output | 1 | Multiplexor-to-pin path enable |
| temp_sel_o | output | 1 | Temperature sensor selected |

## Verification
The conflict that matters most is a done strobe that arrives in the same cycle as a software write clearing run. The bench drives the strobe, carrying a fresh sample, together with the abort write. It then judges that the result registers still hold the previous sample and that run reads 0. A second kind of overlap is a done strobe that arrives while the divide-by-16 start is still pending. The bench checks that this strobe neither ends the conversion nor touches the results, and that the start pulse still appears on schedule.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RESH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RESL = 2'd2;

  typedef struct packed {
    logic            run;
    logic            mux_out;
    logic            div16;
    logic            diff;
    logic [CH_W-1:0] chan;
  } ctrl_t;
endpackage

// File: rtl/adc_ctrl_presc.sv
module adc_ctrl_presc #(
  parameter int DIV_SLOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic div16_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_SLOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == CNT_MAX);
  assign tick_o = run_i & (~div16_i | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || !div16_i)  cnt_q <= '0;
    else if (wrap)                cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R4: divider idles at zero whenever the run bit has been low
  a_r4_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  // R4: slow ticks are isolated while divide-by-16 is held
  a_r4_slow_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div16_i && run_i) |=> (!tick_o || !div16_i));
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              done_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic              done_acc_o
);
  ctrl_t ctrl_q;
  ctrl_t wctrl;
  logic  pend_q;
  logic  ctrl_wr, abort, start_wr;

  assign wctrl      = ctrl_t'(wdata_i);
  assign ctrl_wr    = wr_en_i && (addr_i == ADDR_CTRL);
  assign abort      = ctrl_wr && !wctrl.run;
  assign start_wr   = ctrl_wr && wctrl.run && !ctrl_q.run;
  // done only counts once the start of this conversion has gone out
  assign done_acc_o = done_i && ctrl_q.run && !pend_q && !abort;
  assign start_o    = tick_i && pend_q;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.chan    <= wctrl.chan;
        ctrl_q.diff    <= wctrl.diff;
        ctrl_q.div16   <= wctrl.div16;
        ctrl_q.mux_out <= wctrl.mux_out;
      end
      if (abort)           ctrl_q.run <= 1'b0;
      else if (start_wr)   ctrl_q.run <= 1'b1;
      else if (done_acc_o) ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (abort)    pend_q <= 1'b0;
    else if (start_wr) pend_q <= 1'b1;
    else if (tick_i)   pend_q <= 1'b0;
  end

  // R3: start is a single-cycle pulse
  a_r3_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3: start only while running
  a_r3_start_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ctrl_q.run);
  // R5: accepted done ends the conversion
  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_acc_o && !ctrl_wr) |=> !ctrl_q.run);
  // R6: abort leaves run low
  a_r6_abort_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!ctrl_q.run && !pend_q));
  // R7: write of 1 while running keeps pending state
  a_r7_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wctrl.run && ctrl_q.run && !pend_q) |=> !pend_q);
endmodule

// File: rtl/adc_ctrl_result.sv
module adc_ctrl_result
  import adc_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cap_i,
  input  logic [RES_W-1:0]  data_i,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [DATA_W-1:0] res_lo_o
);
  localparam int LO_W = RES_W - DATA_W;

  logic [DATA_W-1:0] hi_q;
  logic [LO_W-1:0]   lo_q;
  logic              wr_hi, wr_lo;

  assign wr_hi    = wr_en_i && (addr_i == ADDR_RESH);
  assign wr_lo    = wr_en_i && (addr_i == ADDR_RESL);
  assign res_hi_o = hi_q;
  assign res_lo_o = {lo_q, {(DATA_W-LO_W){1'b0}}};

  // capture from the converter takes priority over a CPU write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap_i) begin
      hi_q <= data_i[RES_W-1:LO_W];
      lo_q <= data_i[LO_W-1:0];
    end else begin
      if (wr_hi) hi_q <= wdata_i;
      if (wr_lo) lo_q <= wdata_i[DATA_W-1 -: LO_W];
    end
  end

  // R8: results hold without capture or CPU write
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !wr_hi && !wr_lo) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DIV_SLOW = 16,
  parameter logic [3:0] TEMP_CH = 4'd15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        pga_en_i,
  output logic        conv_clk_en_o,
  output logic        conv_start_o,
  output logic [3:0]  conv_chan_o,
  output logic        conv_diff_o,
  input  logic        conv_done_i,
  input  logic [9:0]  conv_data_i,
  output logic        mux_gate_en_o,
  output logic        pin_path_en_o,
  output logic        temp_sel_o
);
  ctrl_t             ctrl;
  logic              tick, done_acc;
  logic [DATA_W-1:0] res_hi, res_lo;

  adc_ctrl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .tick_i     (tick),
    .done_i     (conv_done_i),
    .ctrl_o     (ctrl),
    .start_o    (conv_start_o),
    .done_acc_o (done_acc)
  );

  adc_ctrl_presc #(.DIV_SLOW(DIV_SLOW)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl.run),
    .div16_i (ctrl.div16),
    .tick_o  (tick)
  );

  adc_ctrl_result u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cap_i    (done_acc),
    .data_i   (conv_data_i),
    .res_hi_o (res_hi),
    .res_lo_o (res_lo)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl;
      ADDR_RESH: rdata_o = res_hi;
      ADDR_RESL: rdata_o = res_lo;
      default:   rdata_o = '0;
    endcase
  end

  assign conv_clk_en_o = tick;
  assign conv_chan_o   = ctrl.chan;
  assign conv_diff_o   = ctrl.diff;
  assign pin_path_en_o = ctrl.mux_out | pga_en_i;
  assign mux_gate_en_o = ctrl.run | pin_path_en_o;
  assign temp_sel_o    = (ctrl.chan == TEMP_CH) && !ctrl.diff;

  // R9: gates closed implies idle
  a_r9_gate_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_gate_en_o |-> !conv_clk_en_o);
  // R6: abort with concurrent done keeps results
  a_r6_abort_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTRL && !wdata_i[7]) |=> ($stable(res_hi) && $stable(res_lo)));
  // R11: done while idle changes nothing
  a_r11_idle_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !ctrl.run && !wr_en_i) |=> ($stable(res_hi) && $stable(res_lo) && !ctrl.run));
  // R10: temp sensor never selected in differential mode
  a_r10_temp_se: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_sel_o |-> !conv_diff_o);
endmodule

// File: tb/adc_ctrl_tb.sv
module adc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pga_en = 1'b0;
  logic       clk_en, start, diff, done = 1'b0;
  logic [3:0] chan;
  logic [9:0] data = 10'd0;
  logic       gate, pin_path, temp_sel;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pga_en_i(pga_en),
    .conv_clk_en_o(clk_en), .conv_start_o(start), .conv_chan_o(chan),
    .conv_diff_o(diff), .conv_done_i(done), .conv_data_i(data),
    .mux_gate_en_o(gate), .pin_path_en_o(pin_path), .temp_sel_o(temp_sel)
  );

  // {addr, wdata, expected readback}
  localparam int NVEC = 8;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h1A, 8'h1A}, {2'd0, 8'h65, 8'h65},
    {2'd1, 8'hC3, 8'hC3}, {2'd2, 8'hFF, 8'hC0},
    {2'd2, 8'h41, 8'h40}, {2'd3, 8'h55, 8'h00},
    {2'd1, 8'h00, 8'h00}, {2'd0, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_done(input logic [9:0] v);
    @(negedge clk);
    done = 1'b1; data = v;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int first_start;
    int ticks;

    repeat (3) @(negedge clk);
    rd(2'd0, r);
    chk("R1 ctrl reset", {8'd0, r}, 16'h0000);
    chk("R1 outputs reset", {12'd0, start, clk_en, gate, temp_sel}, 16'h0000);
    rst_ni = 1'b1;

    // R2 R8 register table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], r);
      chk("R2/R8 readback", {8'd0, r}, {8'd0, VEC[i][7:0]});
    end

    // R9 R10
    wr(2'd0, 8'h40);
    #1 chk("R9 mux_out", {14'd0, gate, pin_path}, 16'h0003);
    pga_en = 1'b1;
    wr(2'd0, 8'h0F);
    #1 chk("R9 pga", {14'd0, gate, pin_path}, 16'h0003);
    chk("R10 temp se", {15'd0, temp_sel}, 16'h0001);
    pga_en = 1'b0;
    wr(2'd0, 8'h1F);
    #1 chk("R10 temp diff", {15'd0, temp_sel}, 16'h0000);
    chk("R9 idle closed", {14'd0, gate, pin_path}, 16'h0000);

    // R11 done while idle
    wr(2'd1, 8'h11);
    pulse_done(10'h3FF);
    rd(2'd1, r);
    chk("R11 idle done", {8'd0, r}, 16'h0011);

    // R3 R4 R5 div-by-1 conversion
    wr(2'd0, 8'h83);
    #1 chk("R3 start div1", {14'd0, start, clk_en}, 16'h0003);
    chk("R9 busy gate", {14'd0, gate, pin_path}, 16'h0002);
    @(negedge clk);
    #1 chk("R3 single pulse", {14'd0, start, clk_en}, 16'h0001);
    pulse_done(10'h2D7);
    rd(2'd1, r);
    chk("R5 high byte", {8'd0, r}, 16'h00B5);
    rd(2'd2, r);
    chk("R5 low bits", {8'd0, r}, 16'h00C0);
    rd(2'd0, r);
    chk("R5 run cleared", {8'd0, r}, 16'h0003);
    chk("R4 clk off", {15'd0, clk_en}, 16'h0000);

    // R6 abort in same cycle as done
    wr(2'd0, 8'h83);
    @(negedge clk);
    addr = 2'd0; wdata = 8'h03; wr_en = 1'b1; done = 1'b1; data = 10'h001;
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0;
    rd(2'd1, r);
    chk("R6 abort high", {8'd0, r}, 16'h00B5);
    rd(2'd2, r);
    chk("R6 abort low", {8'd0, r}, 16'h00C0);
    rd(2'd0, r);
    chk("R6 abort run", {8'd0, r}, 16'h0003);

    // R7 back-to-back restart
    wr(2'd0, 8'h83);
    @(negedge clk);
    addr = 2'd0; wdata = 8'h03; wr_en = 1'b1;
    @(negedge clk);
    #1 chk("R7 stopped", {15'd0, start}, 16'h0000);
    wdata = 8'h83;
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R7 restart pulse", {15'd0, start}, 16'h0001);
    @(negedge clk);
    wr(2'd0, 8'h83);
    #1 chk("R7 no rearm", {15'd0, start}, 16'h0000);
    wr(2'd0, 8'h00);

    // R3 R4 R11 div-by-16 with early done
    wr(2'd0, 8'hA2);
    first_start = -1;
    ticks = 0;
    for (int n = 0; n < 20; n++) begin
      done = (n == 3);
      data = 10'h0AA;
      #1;
      if (start && first_start < 0) first_start = n;
      if (clk_en) ticks++;
      @(negedge clk);
    end
    done = 1'b0;
    chk("R3 div16 start offset", 16'(first_start), 16'd15);
    chk("R4 div16 tick count", 16'(ticks), 16'd1);
    rd(2'd0, r);
    chk("R11 early done ignored", {8'd0, r}, 16'h00A2);
    rd(2'd1, r);
    chk("R11 early done result", {8'd0, r}, 16'h00B5);
    pulse_done(10'h155);
    rd(2'd1, r);
    chk("R5 div16 high", {8'd0, r}, 16'h0055);
    rd(2'd2, r);
    chk("R5 div16 low", {8'd0, r}, 16'h0040);

    // R4 divider restarts from zero after abort
    wr(2'd0, 8'hA2);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'hA2);
    first_start = -1;
    for (int n = 0; n < 18; n++) begin
      #1;
      if (start && first_start < 0) first_start = n;
      @(negedge clk);
    end
    chk("R4 divider phase reset", 16'(first_start), 16'd15);
    wr(2'd0, 8'h00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule